// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit sits next to a small word-addressed memory and serves several requesters that share it. Each requester presents a request with a valid/ready handshake: an opcode, a word address and two operands. A round-robin arbiter accepts at most one request per clock. The accepted operation reads the addressed word, computes its result and writes it back in that same cycle, so no other request can be interleaved inside it. Every operation therefore takes effect in one total order.

The unit offers test-and-set, swap, in-place add/subtract/AND, the fetching forms of those three, compare-and-swap, and a linked load paired with a conditional store. For the linked pair, the unit keeps one reservation per requester. A write to a reserved word by a different requester breaks that reservation. A single response channel returns the requester index, the value the word held before the operation, and a success flag. The response appears in the cycle after acceptance.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Opcode 0 (test-and-set) writes 1 to the word, returns the previous value and reports success 1.
- R2: Opcode 1 (swap) writes operand A, returns the previous value and reports success 1.
- R3: Opcodes 2, 3 and 4 replace the word o with o+A, o-A or o&A, both modulo 2^DATA_W. They return 0 as the old value and report success 1.
- R4: Opcodes 5, 6 and 7 (fetching add, subtract and AND) update the word as R3 does, but return the previous value, with success 1.
- R5: Opcode 8 (compare-and-swap) writes operand B only if the word equals operand A. It always returns the previous value, and its success flag is 1 on a match and 0 otherwise. On a mismatch the word is left unchanged.
- R6: Opcode 9 (linked load) returns the word without writing it, reports success 1, and sets the reservation of the requester on that address. Any earlier reservation of that requester is replaced.
- R7: Opcode 10 (conditional store) writes operand A and reports success 1 only if the requester holds a reservation on that address. Otherwise it reports 0 and writes nothing. It returns the previous value, and in both cases it clears the reservation of that requester.
- R8: Any write to an address clears the reservations that other requesters hold on that address. A write by a requester to its own reserved address leaves its own reservation in place.
- R9: At most one request is accepted per cycle, shown by req_ready. Arbitration is round-robin: after requester i is served, requesters i+1, i+2, ... (wrapping) have priority, and after reset requester 0 has priority.
- R10: rsp_valid is high exactly in the cycle after a request is accepted. It carries that request's index in rsp_id, together with rsp_old and rsp_ok.
- R11: Synchronous reset clears every memory word and every reservation, and holds rsp_valid and all req_ready low.
- R12: Opcodes 11 to 15 return the word without writing it, with success 1, and leave the reservations untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | Per-requester request valid |
| req_ready | output | NREQ | Per-requester accept strobe, at most one bit high |
| req_op | input | NREQ*4 | Opcodes, requester i in bits [4i+3:4i] |
| req_addr | input | NREQ*ADDR_W | Word addresses, requester i in slice i |
| req_opa | input | NREQ*DATA_W | Operand A (value, addend, expected value) |
| req_opb | input | NREQ*DATA_W | Operand B (new value for compare-and-swap) |
| rsp_valid | output | 1 | Response valid |
| rsp_id | output | ID_W | Index of the requester that was served |
| rsp_old | output | DATA_W | Value held before the operation (0 for in-place ops) |
| rsp_ok | output | 1 | Success flag |

## Verification
A wrong memory word does not show at the ports until some later request reads that address. It then appears as a bad rsp_old, one cycle after that request is accepted. A stale or lost reservation shows only as a wrong rsp_ok on a later conditional store. For that reason the random traffic is confined to a few addresses and runs linked pairs from competing requesters. A slip in the arbiter pointer shows at once as a wrong req_ready, and again in rsp_id one cycle later.

// File: rtl/atomu_pkg.sv
package atomu_pkg;

    typedef enum logic [3:0] {
        OP_TAS  = 4'd0,
        OP_SWAP = 4'd1,
        OP_ADD  = 4'd2,
        OP_SUB  = 4'd3,
        OP_AND  = 4'd4,
        OP_FADD = 4'd5,
        OP_FSUB = 4'd6,
        OP_FAND = 4'd7,
        OP_CAS  = 4'd8,
        OP_LL   = 4'd9,
        OP_SC   = 4'd10,
        OP_RSV  = 4'd15
    } op_e;

    localparam int OP_W = 4;

    typedef struct packed {
        logic wr_en;
        logic ok;
        logic is_ll;
        logic is_sc;
    } ctl_t;

    function automatic int id_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/atomu_arbiter.sv
module atomu_arbiter
    import atomu_pkg::*;
#(
    parameter int NREQ = 4,
    localparam int IDW = id_width(NREQ)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NREQ-1:0] req,
    output logic [NREQ-1:0] gnt,
    output logic [IDW-1:0]  gnt_idx,
    output logic            gnt_any
);

    logic [IDW-1:0] last_q;

    always_comb begin
        int c;
        gnt     = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int k = 0; k < NREQ; k++) begin
            c = (int'(last_q) + 1 + k) % NREQ;
            if (!rst && !gnt_any && req[c]) begin
                gnt_any = 1'b1;
                gnt[c]  = 1'b1;
                gnt_idx = IDW'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          last_q <= IDW'(NREQ - 1);
        else if (gnt_any) last_q <= gnt_idx;
    end

    p_one_grant_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    // R9: the same requester is served twice in a row only when nobody else asks
    p_no_repeat_r9: assert property (@(posedge clk) disable iff (rst)
        (gnt_any && gnt == $past(gnt)) |-> ($countones(req) == 1));

endmodule

// File: rtl/atomu_exec.sv
module atomu_exec
    import atomu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              resv_hit,
    output ctl_t              ctl,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ret
);

    always_comb begin
        ctl   = '{wr_en: 1'b0, ok: 1'b1, is_ll: 1'b0, is_sc: 1'b0};
        wdata = cur;
        ret   = cur;
        unique case (op)
            OP_TAS:  begin ctl.wr_en = 1'b1; wdata = DATA_W'(1); end
            OP_SWAP: begin ctl.wr_en = 1'b1; wdata = opa; end
            OP_ADD:  begin ctl.wr_en = 1'b1; wdata = cur + opa; ret = '0; end
            OP_SUB:  begin ctl.wr_en = 1'b1; wdata = cur - opa; ret = '0; end
            OP_AND:  begin ctl.wr_en = 1'b1; wdata = cur & opa; ret = '0; end
            OP_FADD: begin ctl.wr_en = 1'b1; wdata = cur + opa; end
            OP_FSUB: begin ctl.wr_en = 1'b1; wdata = cur - opa; end
            OP_FAND: begin ctl.wr_en = 1'b1; wdata = cur & opa; end
            OP_CAS: begin
                ctl.ok    = (cur == opa);
                ctl.wr_en = (cur == opa);
                wdata     = opb;
            end
            OP_LL: ctl.is_ll = 1'b1;
            OP_SC: begin
                ctl.is_sc = 1'b1;
                ctl.ok    = resv_hit;
                ctl.wr_en = resv_hit;
                wdata     = opa;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/atomu_resv.sv
module atomu_resv
    import atomu_pkg::*;
#(
    parameter int NREQ   = 4,
    parameter int ADDR_W = 4,
    localparam int IDW = id_width(NREQ)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [IDW-1:0]    id,
    input  logic [ADDR_W-1:0] addr,
    input  ctl_t              ctl,
    output logic              hit
);

    logic [NREQ-1:0]   rv_q;
    logic [ADDR_W-1:0] ra_q [NREQ];

    assign hit = rv_q[id] && (ra_q[id] == addr);

    for (genvar r = 0; r < NREQ; r++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                rv_q[r] <= 1'b0;
                ra_q[r] <= '0;
            end else if (fire) begin
                if (IDW'(r) == id) begin
                    if (ctl.is_ll) begin
                        rv_q[r] <= 1'b1;
                        ra_q[r] <= addr;
                    end else if (ctl.is_sc) begin
                        rv_q[r] <= 1'b0;
                    end
                end else if (ctl.wr_en && ra_q[r] == addr) begin
                    rv_q[r] <= 1'b0;
                end
            end
        end
    end

    p_sc_drops_own_r7: assert property (@(posedge clk) disable iff (rst)
        (fire && ctl.is_sc) |=> !rv_q[$past(id)]);

    p_ll_sets_own_r6: assert property (@(posedge clk) disable iff (rst)
        (fire && ctl.is_ll) |=> (rv_q[$past(id)] && ra_q[$past(id)] == $past(addr)));

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
    import atomu_pkg::*;
#(
    parameter int NREQ   = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    localparam int IDW   = id_width(NREQ),
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NREQ-1:0]          req_valid,
    output logic [NREQ-1:0]          req_ready,
    input  logic [NREQ*OP_W-1:0]     req_op,
    input  logic [NREQ*ADDR_W-1:0]   req_addr,
    input  logic [NREQ*DATA_W-1:0]   req_opa,
    input  logic [NREQ*DATA_W-1:0]   req_opb,
    output logic                     rsp_valid,
    output logic [IDW-1:0]           rsp_id,
    output logic [DATA_W-1:0]        rsp_old,
    output logic                     rsp_ok
);

    logic [OP_W-1:0]   op_a   [NREQ];
    logic [ADDR_W-1:0] addr_a [NREQ];
    logic [DATA_W-1:0] opa_a  [NREQ];
    logic [DATA_W-1:0] opb_a  [NREQ];

    for (genvar i = 0; i < NREQ; i++) begin : g_unpack
        assign op_a[i]   = req_op[i*OP_W +: OP_W];
        assign addr_a[i] = req_addr[i*ADDR_W +: ADDR_W];
        assign opa_a[i]  = req_opa[i*DATA_W +: DATA_W];
        assign opb_a[i]  = req_opb[i*DATA_W +: DATA_W];
    end

    logic [IDW-1:0] gidx;
    logic           fire;

    atomu_arbiter #(.NREQ(NREQ)) arb_i (
        .clk(clk), .rst(rst), .req(req_valid),
        .gnt(req_ready), .gnt_idx(gidx), .gnt_any(fire)
    );

    op_e               sel_op;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] cur, wdata, ret;
    logic              hit;
    ctl_t              ctl;
    logic [DATA_W-1:0] mem_q [DEPTH];

    assign sel_op   = op_e'(op_a[gidx]);
    assign sel_addr = addr_a[gidx];
    assign cur      = mem_q[sel_addr];

    atomu_exec #(.DATA_W(DATA_W)) exec_i (
        .op(sel_op), .cur(cur), .opa(opa_a[gidx]), .opb(opb_a[gidx]),
        .resv_hit(hit), .ctl(ctl), .wdata(wdata), .ret(ret)
    );

    atomu_resv #(.NREQ(NREQ), .ADDR_W(ADDR_W)) resv_i (
        .clk(clk), .rst(rst), .fire(fire), .id(gidx),
        .addr(sel_addr), .ctl(ctl), .hit(hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++) mem_q[a] <= '0;
        end else if (fire && ctl.wr_en) begin
            mem_q[sel_addr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_id    <= '0;
            rsp_old   <= '0;
            rsp_ok    <= 1'b0;
        end else begin
            rsp_valid <= fire;
            if (fire) begin
                rsp_id  <= gidx;
                rsp_old <= ret;
                rsp_ok  <= ctl.ok;
            end
        end
    end

    p_rsp_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
        fire |=> (rsp_valid && rsp_id == $past(gidx)));

    p_no_rsp_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !rsp_valid);

    p_cas_miss_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        (fire && sel_op == OP_CAS && !ctl.ok) |=> (mem_q[$past(sel_addr)] == $past(cur)));

endmodule

// File: tb/atomic_rmw_unit_tb_top.sv
`timescale 1ns/100ps
module atomic_rmw_unit_tb_top;

    localparam int N = 4;
    localparam int AW = 4;
    localparam int DW = 16;

    typedef struct packed {
        logic [3:0]    op;
        logic [AW-1:0] addr;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
    } rq_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    req_valid = '0;
    logic [N-1:0]    req_ready;
    logic [N*4-1:0]  req_op = '0;
    logic [N*AW-1:0] req_addr = '0;
    logic [N*DW-1:0] req_opa = '0;
    logic [N*DW-1:0] req_opb = '0;
    logic            rsp_valid;
    logic [1:0]      rsp_id;
    logic [DW-1:0]   rsp_old;
    logic            rsp_ok;

    always #2.5 clk = ~clk;

    atomic_rmw_unit #(.NREQ(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_opa(req_opa), .req_opb(req_opb),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_old(rsp_old), .rsp_ok(rsp_ok)
    );

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    rq_t           q [N][$];
    logic [DW-1:0] m_mem [16];
    bit            m_rv [N];
    int            m_ra [N];
    int            m_last;
    bit            e_valid;
    int            e_id, e_op;
    logic [DW-1:0] e_old;
    bit            e_ok;

    function automatic string tag_of(int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2, 3, 4: return "R3";
            5, 6, 7: return "R4";
            8: return "R5";
            9: return "R6";
            10: return "R7 R8";
            default: return "R12 R11";
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(input int r, input int op, input int addr, input int a, input int b);
        rq_t x;
        x.op = 4'(op); x.addr = AW'(addr); x.a = DW'(a); x.b = DW'(b);
        q[r].push_back(x);
    endtask

    // One cycle: check outputs of the previous step, drive, then advance the model.
    task automatic step();
        int g;
        logic [N-1:0] exp_rdy;
        rq_t x;
        logic [DW-1:0] o, nv;
        bit wr, ok, hit;
        @(negedge clk);
        check("R10 valid", int'(rsp_valid), int'(e_valid));
        if (e_valid && rsp_valid) begin
            check("R10 R9 id", int'(rsp_id), e_id);
            check({tag_of(e_op), " old"}, int'(rsp_old), int'(e_old));
            check({tag_of(e_op), " ok"}, int'(rsp_ok), int'(e_ok));
        end
        for (int r = 0; r < N; r++) begin
            req_valid[r] = (q[r].size() != 0);
            if (q[r].size() != 0) begin
                x = q[r][0];
                req_op[r*4 +: 4]     = x.op;
                req_addr[r*AW +: AW] = x.addr;
                req_opa[r*DW +: DW]  = x.a;
                req_opb[r*DW +: DW]  = x.b;
            end
        end
        #1;
        g = -1;
        for (int k = 0; k < N; k++) begin
            int c;
            c = (m_last + 1 + k) % N;
            if (g < 0 && q[c].size() != 0) g = c;
        end
        exp_rdy = '0;
        if (g >= 0) exp_rdy[g] = 1'b1;
        check("R9 ready", int'(req_ready), int'(exp_rdy));
        e_valid = (g >= 0);
        if (g < 0) return;
        m_last = g;
        x = q[g].pop_front();
        o = m_mem[x.addr];
        hit = m_rv[g] && (m_ra[g] == int'(x.addr));
        wr = 1; ok = 1; nv = o; e_old = o;
        case (int'(x.op))
            0: nv = 1;
            1: nv = x.a;
            2: begin nv = o + x.a; e_old = 0; end
            3: begin nv = o - x.a; e_old = 0; end
            4: begin nv = o & x.a; e_old = 0; end
            5: nv = o + x.a;
            6: nv = o - x.a;
            7: nv = o & x.a;
            8: begin ok = (o == x.a); wr = ok; nv = x.b; end
            9: begin wr = 0; m_rv[g] = 1; m_ra[g] = int'(x.addr); end
            10: begin ok = hit; wr = hit; nv = x.a; m_rv[g] = 0; end
            default: wr = 0;
        endcase
        if (wr) begin
            m_mem[x.addr] = nv;
            for (int r = 0; r < N; r++)
                if (r != g && m_ra[r] == int'(x.addr)) m_rv[r] = 0;
        end
        e_id = g; e_op = int'(x.op); e_ok = ok;
    endtask

    task automatic drain();
        bit busy;
        busy = 1;
        while (busy) begin
            step();
            busy = 0;
            for (int r = 0; r < N; r++) if (q[r].size() != 0) busy = 1;
        end
        step();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        for (int a = 0; a < 16; a++) m_mem[a] = '0;
        for (int r = 0; r < N; r++) begin m_rv[r] = 0; m_ra[r] = 0; end
        m_last = N - 1;
        e_valid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 rsp_valid in reset", int'(rsp_valid), 0);
        check("R11 ready in reset", int'(req_ready), 0);
        rst = 1'b0;

        // R11 memory cleared, R12 undefined opcode reads only
        push(0, 12, 5, 0, 0); push(0, 14, 15, 0, 0); drain();
        // R2 swap then read back
        push(0, 1, 1, 16'h1234, 0); push(0, 13, 1, 0, 0); drain();
        // R1 test-and-set twice
        push(1, 0, 2, 0, 0); push(1, 0, 2, 0, 0); drain();
        // R3 in-place ops with wrap, R4 fetching ops
        push(2, 2, 3, 5, 0); push(2, 5, 3, 3, 0); push(2, 3, 3, 10, 0);
        push(2, 6, 3, 1, 0); push(2, 4, 3, 16'h00F0, 0); push(2, 7, 3, 16'h0F0F, 0);
        push(2, 11, 3, 0, 0); drain();
        // R5 hit then miss
        push(3, 8, 1, 16'h1234, 7); push(3, 8, 1, 16'h1234, 9); push(3, 15, 1, 0, 0); drain();
        // R7 success then repeat fails (own reservation cleared)
        push(2, 9, 4, 0, 0); push(2, 10, 4, 9, 0); push(2, 10, 4, 11, 0); push(2, 13, 4, 0, 0); drain();
        // R8 another requester's store breaks the reservation
        push(2, 9, 4, 0, 0); drain(); push(3, 9, 4, 0, 0); drain();
        push(3, 10, 4, 21, 0); drain(); push(2, 10, 4, 22, 0); drain();
        // R8 own plain write keeps own reservation
        push(1, 9, 6, 0, 0); push(1, 1, 6, 33, 0); push(1, 10, 6, 34, 0); drain();
        // R6 new linked load replaces the older reservation
        push(1, 9, 6, 0, 0); push(1, 9, 7, 0, 0); push(1, 10, 6, 40, 0); drain();
        // R12 undefined opcode leaves reservation intact
        push(0, 9, 8, 0, 0); push(0, 12, 8, 0, 0); push(0, 10, 8, 5, 0); drain();
        // R9 all requesters contend
        for (int k = 0; k < 3; k++)
            for (int r = 0; r < N; r++) push(r, 5, 9, r + 1, 0);
        drain();

        // mixed random traffic on few addresses
        for (int cyc = 0; cyc < 4000; cyc++) begin
            for (int r = 0; r < N; r++) begin
                if (q[r].size() == 0 && ($urandom % 4) != 0) begin
                    int op;
                    op = int'($urandom % 16);
                    if (($urandom % 3) == 0) op = 9 + int'($urandom % 2);
                    push(r, op, int'($urandom % 3), int'($urandom % 4), int'($urandom % 4));
                end
            end
            step();
        end
        drain();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule